// File: doc/BRIEF.md
# Pin-Driven Frequency Step Controller

This block holds the frequency word of one synthesizer, in kHz, and moves it up or down by a single programmed step. Two external pins request the moves, one to raise the frequency and one to lower it. A request only counts if the pin shows a clean pulse. That means a high phase of at least a set number of clock cycles, then a low phase of at least a set number of cycles. Once the block has acted on a request, it ignores any further request until a guard window has passed. This limits the rate at which the frequency can change.

The word is kept inside a window. The lower limit is a configuration input. The upper limit is also a configuration input and stands for one-eighth of the oscillator frequency. A decrement that would drop below the lower limit is refused: the word does not change and a refuse pulse is raised. An increment that would go past the upper limit mutes the output for a fixed number of cycles and then restores the previous word. Requests are blocked while spread spectrum is enabled on the output.

The block also reports the step as seen behind a power-of-two output divider, and flags divider codes that do not exist. The block does not generate any clock. Its outputs are the word, the mute flag, the status strobes and the scaled step.

Top module: `freq_step_ctrl`

## Requirements
- R1: After reset, `freq_khz_o` equals the parameter INIT_KHZ, and `mute_o`, `done_o` and `refuse_o` are all 0.
- R2: A qualified increment request adds `step_khz_i` to the word when the sum does not exceed `ceil_khz_i`. A sum exactly equal to the ceiling is accepted. `done_o` pulses high for exactly one cycle, in the cycle the new word appears.
- R3: A qualified decrement request subtracts `step_khz_i` from the word when the result is not below `floor_khz_i`. A result exactly equal to the floor is accepted. `done_o` pulses for one cycle.
- R4: A request is qualified only when the synchronized pin is high for at least HIGH_CYC consecutive cycles and then low for at least LOW_CYC consecutive cycles. A shorter high phase is ignored. A shorter low phase that is followed by a new high phase is discarded. A single qualified pulse yields exactly one request.
- R5: After a request is acted on (applied, refused or causing a mute), any request arriving within the next GUARD_CYC cycles is ignored. The first request after the window is accepted.
- R6: An increment whose sum exceeds `ceil_khz_i` (or the word width) raises `mute_o` for exactly MUTE_CYC cycles. When `mute_o` falls, the word is back at its value from before the increment, and `done_o` pulses once, in that same cycle.
- R7: A decrement whose result would be below `floor_khz_i`, or below zero, leaves the word unchanged. It raises `refuse_o` for one cycle, with no `done_o` pulse and no mute.
- R8: While `ss_en_i` is 1, requests on either pin are ignored.
- R9: Requests qualified on both pins in the same cycle cancel: the word does not change.
- R10: `step_out_khz_o` is `step_khz_i` shifted right by `div_code_i` for codes 0 to 5 (ratios 1, 2, 4, 8, 16, 32), with `div_bad_o` = 0. For codes 6 and 7, `step_out_khz_o` is 0 and `div_bad_o` is 1. The result is registered and appears one cycle after the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_pin_i | input | 1 | Raw increment request pin |
| dec_pin_i | input | 1 | Raw decrement request pin |
| ss_en_i | input | 1 | Spread spectrum enabled; blocks stepping |
| step_khz_i | input | FW | Programmed step, kHz |
| floor_khz_i | input | FW | Lowest permitted word, kHz |
| ceil_khz_i | input | FW | Highest permitted word (oscillator/8), kHz |
| div_code_i | input | 3 | Output divider code, ratio = 2^code |
| freq_khz_o | output | FW | Current frequency word, kHz |
| mute_o | output | 1 | Output muted after an overshoot |
| done_o | output | 1 | One-cycle strobe on update or end of mute |
| refuse_o | output | 1 | One-cycle strobe on a refused decrement |
| step_out_khz_o | output | FW | Step seen after the output divider, kHz |
| div_bad_o | output | 1 | Divider code out of range |

## Verification
The bench targets the exact boundaries of the window: one step landing exactly on the ceiling or the floor, and one step past each. An off-by-one compare there would either reject a legal step or let the word leave the window. It then drives pulses that are too narrow, pulses with a low phase cut short, back-to-back pulses inside the guard window, and simultaneous pulses on both pins. A qualifier or rate limiter that got these wrong would step more than once or step on noise. The overshoot case counts mute cycles and the done strobe, and checks that the word is restored; a wrong counter length or a missing rollback would show up there. A table covers all eight divider codes, including the two invalid ones.

// File: rtl/freq_step_pkg.sv
package freq_step_pkg;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_MUTE = 1'b1
    } fsc_state_e;

    localparam int DIV_CODE_W  = 3;
    localparam int DIV_RATIOS  = 6;
    localparam int PIN_COUNT   = 2;
    localparam int PIN_INC     = 0;
    localparam int PIN_DEC     = 1;

endpackage

// File: rtl/fsc_pin_qual.sv
module fsc_pin_qual #(
    parameter int HIGH_CYC    = 26,
    parameter int LOW_CYC     = 26,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic evt_o
);

    localparam int MAXC = (HIGH_CYC > LOW_CYC) ? HIGH_CYC : LOW_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] HI_LIM = CW'(HIGH_CYC);
    localparam logic [CW-1:0] LO_LIM = CW'(LOW_CYC);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          hi_cnt;
        logic [CW-1:0]          lo_cnt;
        logic                   armed;
        logic                   evt;
    } qual_t;

    qual_t st_d, st_q;
    logic  lvl;
    logic [CW-1:0] lo_next;

    assign lvl = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.evt  = 1'b0;
        lo_next   = '0;
        if (SYNC_STAGES > 1) begin
            st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_i};
        end else begin
            st_d.sync = pin_i;
        end
        if (lvl) begin
            st_d.lo_cnt = '0;
            st_d.armed  = 1'b0;
            if (st_q.hi_cnt != HI_LIM) begin
                st_d.hi_cnt = st_q.hi_cnt + 1'b1;
            end
        end else begin
            st_d.hi_cnt = '0;
            if (st_q.armed || st_q.hi_cnt == HI_LIM) begin
                lo_next = (st_q.armed ? st_q.lo_cnt : '0) + 1'b1;
                if (lo_next == LO_LIM) begin
                    st_d.evt    = 1'b1;
                    st_d.armed  = 1'b0;
                    st_d.lo_cnt = '0;
                end else begin
                    st_d.armed  = 1'b1;
                    st_d.lo_cnt = lo_next;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o = st_q.evt;

    // R4
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt |=> !st_q.evt);

    // R4
    evt_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.evt) |-> !$past(lvl));

endmodule

// File: rtl/fsc_step_scale.sv
module fsc_step_scale
    import freq_step_pkg::*;
#(
    parameter int FW = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [FW-1:0]         step_i,
    input  logic [DIV_CODE_W-1:0] code_i,
    output logic [FW-1:0]         step_o,
    output logic                  bad_o
);

    typedef struct packed {
        logic [FW-1:0] step;
        logic          bad;
    } scale_t;

    scale_t st_d, st_q;
    logic [FW-1:0] shifted [DIV_RATIOS];

    for (genvar g = 0; g < DIV_RATIOS; g++) begin : g_shift
        assign shifted[g] = step_i >> g;
    end

    always_comb begin
        st_d.step = '0;
        st_d.bad  = 1'b1;
        for (int k = 0; k < DIV_RATIOS; k++) begin
            if (code_i == DIV_CODE_W'(k)) begin
                st_d.step = shifted[k];
                st_d.bad  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign step_o = st_q.step;
    assign bad_o  = st_q.bad;

    // R10
    bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bad |-> (st_q.step == '0));

    // R10
    scale_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.bad |-> (st_q.step <= $past(step_i)));

endmodule

// File: rtl/fsc_core.sv
module fsc_core
    import freq_step_pkg::*;
#(
    parameter int FW        = 24,
    parameter int INIT_KHZ  = 100000,
    parameter int GUARD_CYC = 167,
    parameter int MUTE_CYC  = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_evt_i,
    input  logic          dec_evt_i,
    input  logic          ss_en_i,
    input  logic [FW-1:0] step_i,
    input  logic [FW-1:0] floor_i,
    input  logic [FW-1:0] ceil_i,
    output logic [FW-1:0] word_o,
    output logic          mute_o,
    output logic          done_o,
    output logic          refuse_o
);

    localparam int GW = $clog2(GUARD_CYC + 1);
    localparam int MW = $clog2(MUTE_CYC + 1);
    localparam logic [GW-1:0] GUARD_LD = GW'(GUARD_CYC);
    localparam logic [MW-1:0] MUTE_LD  = MW'(MUTE_CYC - 1);
    localparam logic [FW-1:0] INIT_W   = FW'(INIT_KHZ);

    typedef struct packed {
        fsc_state_e    state;
        logic [FW-1:0] word;
        logic [FW-1:0] saved;
        logic [MW-1:0] mute_cnt;
        logic [GW-1:0] guard;
        logic          done;
        logic          refuse;
    } core_t;

    core_t st_d, st_q;
    logic          take;
    logic [FW:0]   sum;
    logic [FW-1:0] diff;

    assign sum  = {1'b0, st_q.word} + {1'b0, step_i};
    assign diff = st_q.word - step_i;
    assign take = (inc_evt_i ^ dec_evt_i) && !ss_en_i && (st_q.guard == '0);

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.refuse = 1'b0;
        if (st_q.guard != '0) begin
            st_d.guard = st_q.guard - 1'b1;
        end
        unique case (st_q.state)
            ST_RUN: begin
                if (take) begin
                    st_d.guard = GUARD_LD;
                    if (inc_evt_i) begin
                        if (sum > {1'b0, ceil_i}) begin
                            st_d.state    = ST_MUTE;
                            st_d.saved    = st_q.word;
                            st_d.word     = sum[FW-1:0];
                            st_d.mute_cnt = MUTE_LD;
                        end else begin
                            st_d.word = sum[FW-1:0];
                            st_d.done = 1'b1;
                        end
                    end else begin
                        if (st_q.word < step_i || diff < floor_i) begin
                            st_d.refuse = 1'b1;
                        end else begin
                            st_d.word = diff;
                            st_d.done = 1'b1;
                        end
                    end
                end
            end
            ST_MUTE: begin
                if (st_q.mute_cnt == '0) begin
                    st_d.state = ST_RUN;
                    st_d.word  = st_q.saved;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.mute_cnt = st_q.mute_cnt - 1'b1;
                end
            end
            default: st_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state    <= ST_RUN;
            st_q.word     <= INIT_W;
            st_q.saved    <= INIT_W;
            st_q.mute_cnt <= '0;
            st_q.guard    <= '0;
            st_q.done     <= 1'b0;
            st_q.refuse   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o   = st_q.word;
    assign mute_o   = (st_q.state == ST_MUTE);
    assign done_o   = st_q.done;
    assign refuse_o = st_q.refuse;

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R6
    mute_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_o && $past(mute_o)) |-> (st_q.word == $past(st_q.word)));

    // R6
    revert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mute_o) |-> (st_q.word == st_q.saved && st_q.done));

    // R6
    mute_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mute_o |-> (st_q.mute_cnt < MW'(MUTE_CYC)));

    // R7
    refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.refuse |-> (st_q.word == $past(st_q.word) && !mute_o && !st_q.done));

    // R8
    ss_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ss_en_i) && !mute_o && !$past(mute_o)) |-> (st_q.word == $past(st_q.word)));

    // R5
    guard_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mute_o && !$past(mute_o) && st_q.word != $past(st_q.word)) |-> ($past(st_q.guard) == '0));

endmodule

// File: rtl/freq_step_ctrl.sv
module freq_step_ctrl
    import freq_step_pkg::*;
#(
    parameter int FW          = 24,
    parameter int INIT_KHZ    = 100000,
    parameter int HIGH_CYC    = 26,
    parameter int LOW_CYC     = 26,
    parameter int SYNC_STAGES = 2,
    parameter int GUARD_CYC   = 167,
    parameter int MUTE_CYC    = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inc_pin_i,
    input  logic                  dec_pin_i,
    input  logic                  ss_en_i,
    input  logic [FW-1:0]         step_khz_i,
    input  logic [FW-1:0]         floor_khz_i,
    input  logic [FW-1:0]         ceil_khz_i,
    input  logic [DIV_CODE_W-1:0] div_code_i,
    output logic [FW-1:0]         freq_khz_o,
    output logic                  mute_o,
    output logic                  done_o,
    output logic                  refuse_o,
    output logic [FW-1:0]         step_out_khz_o,
    output logic                  div_bad_o
);

    logic [PIN_COUNT-1:0] pins;
    logic [PIN_COUNT-1:0] evts;

    assign pins[PIN_INC] = inc_pin_i;
    assign pins[PIN_DEC] = dec_pin_i;

    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_qual
        fsc_pin_qual #(
            .HIGH_CYC    (HIGH_CYC),
            .LOW_CYC     (LOW_CYC),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_i (pins[p]),
            .evt_o (evts[p])
        );
    end

    fsc_core #(
        .FW        (FW),
        .INIT_KHZ  (INIT_KHZ),
        .GUARD_CYC (GUARD_CYC),
        .MUTE_CYC  (MUTE_CYC)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_evt_i (evts[PIN_INC]),
        .dec_evt_i (evts[PIN_DEC]),
        .ss_en_i   (ss_en_i),
        .step_i    (step_khz_i),
        .floor_i   (floor_khz_i),
        .ceil_i    (ceil_khz_i),
        .word_o    (freq_khz_o),
        .mute_o    (mute_o),
        .done_o    (done_o),
        .refuse_o  (refuse_o)
    );

    fsc_step_scale #(
        .FW (FW)
    ) u_scale (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step_khz_i),
        .code_i (div_code_i),
        .step_o (step_out_khz_o),
        .bad_o  (div_bad_o)
    );

    // R9
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evts[PIN_INC] && evts[PIN_DEC] && !mute_o) |=> (freq_khz_o == $past(freq_khz_o) && !done_o && !refuse_o));

endmodule

// File: tb/freq_step_ctrl_bench.sv
module freq_step_ctrl_bench;

    localparam int FW        = 24;
    localparam int INIT_KHZ  = 100000;
    localparam int HIGH_CYC  = 26;
    localparam int LOW_CYC   = 26;
    localparam int GUARD_CYC = 167;
    localparam int MUTE_CYC  = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inc_pin = 1'b0;
    logic          dec_pin = 1'b0;
    logic          ss_en = 1'b0;
    logic [FW-1:0] step_khz = 24'd1000;
    logic [FW-1:0] floor_khz = 24'd5000;
    logic [FW-1:0] ceil_khz = 24'd125000;
    logic [2:0]    div_code = 3'd0;
    logic [FW-1:0] freq_khz;
    logic          mute;
    logic          done;
    logic          refuse;
    logic [FW-1:0] step_out;
    logic          div_bad;

    int n_cmp = 0;
    int n_bad = 0;
    int done_cnt = 0;
    int mute_cnt = 0;
    int refuse_cnt = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    freq_step_ctrl u_freq_step_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .inc_pin_i      (inc_pin),
        .dec_pin_i      (dec_pin),
        .ss_en_i        (ss_en),
        .step_khz_i     (step_khz),
        .floor_khz_i    (floor_khz),
        .ceil_khz_i     (ceil_khz),
        .div_code_i     (div_code),
        .freq_khz_o     (freq_khz),
        .mute_o         (mute),
        .done_o         (done),
        .refuse_o       (refuse),
        .step_out_khz_o (step_out),
        .div_bad_o      (div_bad)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            done_cnt   <= done_cnt + int'(done);
            mute_cnt   <= mute_cnt + int'(mute);
            refuse_cnt <= refuse_cnt + int'(refuse);
        end
    end

    typedef struct packed {
        logic [2:0]    code;
        logic [FW-1:0] step;
        logic [FW-1:0] exp;
        logic          bad;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{3'd0, 24'd2560, 24'd2560, 1'b0},
        '{3'd1, 24'd2560, 24'd1280, 1'b0},
        '{3'd2, 24'd2560, 24'd640,  1'b0},
        '{3'd3, 24'd2560, 24'd320,  1'b0},
        '{3'd4, 24'd2560, 24'd160,  1'b0},
        '{3'd5, 24'd2560, 24'd80,   1'b0},
        '{3'd6, 24'd2560, 24'd0,    1'b1},
        '{3'd7, 24'd2560, 24'd0,    1'b1},
        '{3'd3, 24'd1000, 24'd125,  1'b0}
    };

    task automatic check(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(input bit on_inc, input bit on_dec, input int hi, input int lo);
        inc_pin = on_inc;
        dec_pin = on_dec;
        repeat (hi) @(negedge clk);
        inc_pin = 1'b0;
        dec_pin = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic settle();
        repeat (GUARD_CYC + 15) @(negedge clk);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int d0, m0, r0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 word", freq_khz, INIT_KHZ);
        check("R1 mute", mute, 0);
        check("R1 done", done, 0);
        check("R1 refuse", refuse, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 divider table
        for (int i = 0; i < 9; i++) begin
            div_code = VECS[i].code;
            step_khz = VECS[i].step;
            @(negedge clk);
            check("R10 scaled", step_out, VECS[i].exp);
            check("R10 bad", div_bad, VECS[i].bad);
        end
        div_code = 3'd0;
        step_khz = 24'd1000;
        settle();

        // R2 increment
        d0 = done_cnt;
        pulse(1, 0, 30, 34);
        check("R2 inc", freq_khz, 101000);
        check("R2 done once", done_cnt - d0, 1);
        settle();

        // R3 decrement
        pulse(0, 1, 30, 34);
        check("R3 dec", freq_khz, 100000);
        settle();

        // R4 narrow high ignored
        d0 = done_cnt;
        pulse(1, 0, 10, 40);
        check("R4 narrow high", freq_khz, 100000);
        check("R4 narrow no done", done_cnt - d0, 0);
        // R4 short low discarded, one step from the rest
        inc_pin = 1'b1; repeat (30) @(negedge clk);
        inc_pin = 1'b0; repeat (10) @(negedge clk);
        pulse(1, 0, 30, 34);
        check("R4 short low single step", freq_khz, 101000);
        settle();

        // R5 guard window
        pulse(1, 0, 30, 30);
        pulse(1, 0, 30, 34);
        check("R5 second ignored", freq_khz, 102000);
        settle();
        pulse(1, 0, 30, 34);
        check("R5 accepted after window", freq_khz, 103000);
        settle();

        // R8 spread spectrum blocks
        ss_en = 1'b1;
        pulse(1, 0, 30, 34);
        check("R8 ss blocked", freq_khz, 103000);
        ss_en = 1'b0;
        settle();

        // R9 simultaneous requests cancel
        d0 = done_cnt;
        pulse(1, 1, 30, 34);
        check("R9 cancel", freq_khz, 103000);
        check("R9 no done", done_cnt - d0, 0);
        settle();

        // R2 land exactly on ceiling
        step_khz = 24'd22000;
        pulse(1, 0, 30, 34);
        check("R2 ceiling exact", freq_khz, 125000);
        settle();

        // R6 overshoot mute and revert
        d0 = done_cnt;
        m0 = mute_cnt;
        pulse(1, 0, 30, 40);
        check("R6 mute cycles", mute_cnt - m0, MUTE_CYC);
        check("R6 reverted", freq_khz, 125000);
        check("R6 done once", done_cnt - d0, 1);
        check("R6 mute cleared", mute, 0);
        settle();

        // R3 land exactly on floor
        step_khz = 24'd1000;
        floor_khz = 24'd124000;
        pulse(0, 1, 30, 34);
        check("R3 floor exact", freq_khz, 124000);
        settle();

        // R7 refuse below floor
        d0 = done_cnt;
        m0 = mute_cnt;
        r0 = refuse_cnt;
        pulse(0, 1, 30, 34);
        check("R7 word held", freq_khz, 124000);
        check("R7 refuse pulse", refuse_cnt - r0, 1);
        check("R7 no done", done_cnt - d0, 0);
        check("R7 no mute", mute_cnt - m0, 0);
        settle();

        // R7 step larger than word
        floor_khz = 24'd0;
        step_khz = 24'd200000;
        r0 = refuse_cnt;
        pulse(0, 1, 30, 34);
        check("R7 no underflow", freq_khz, 124000);
        check("R7 refuse underflow", refuse_cnt - r0, 1);

        report();
    end

endmodule